// File: doc/BRIEF.md
# Bus-Invert Burst Output Encoder

This block sits on the read-data path of a memory device and cuts the number of output pins that switch during burst reads. It keeps the word it last drove on the output bus. For each new burst word it counts how many bits would change against that word. If more than half the bus would flip, it drives the complement instead and raises a polarity flag next to the data. Non-burst reads, and all reads while the function is off, leave the data unchanged and keep the flag low.

The function starts switched off. A single enable command turns it on, and only a reset turns it off again. While it is on, every burst gets one extra wait cycle before its first word and one before its second word. The ready output shows these wait cycles. A read presented during a wait cycle is not taken. A separate receive path handles write and command data: a polarity input from the host says whether the incoming word arrives complemented, and the block restores the true word.

Top module: `bi_burst_encoder`

## Requirements
- R1: After reset, `dq_o` is all zeros, `pol_o` is 0, `rdy_o` is 1, `wr_valid_o` is 0 and the encoding function is off.
- R2: A one-cycle pulse on `enable_cmd_i` turns the function on from the next cycle. Further pulses change nothing, and only `rst` turns it off.
- R3: A burst read word (`rd_burst_i`=1) accepted while the function is on appears on `dq_o` one cycle later. If 9 or more bits differ from the current `dq_o`, the bus carries the bitwise complement and `pol_o`=1. Otherwise it carries the word unchanged and `pol_o`=0. Complementing `dq_o` whenever `pol_o`=1 gives back the accepted word.
- R4: A burst word that differs from the current `dq_o` in exactly 8 bits is driven unchanged with `pol_o`=0.
- R5: The comparison is always made against the value last driven on `dq_o`, after any inversion. That value is kept across bursts and across non-burst reads, and `dq_o`/`pol_o` stay unchanged in cycles where no read is accepted.
- R6: A non-burst read (`rd_burst_i`=0), or any read while the function is off, is driven unchanged with `pol_o`=0.
- R7: While the function is on, a `burst_start_i` pulse drives `rdy_o` low for exactly the next cycle. After the first word of that burst is accepted, `rdy_o` is low for exactly one more cycle. A read is accepted only when `rd_valid_i`=1, `rdy_o`=1 and `burst_start_i`=0, and a read presented while `rdy_o`=0 leaves `dq_o` unchanged.
- R8: While the function is off, `rdy_o` stays 1, including after `burst_start_i`.
- R9: A write word with `wr_valid_i`=1 appears one cycle later on `wr_data_o`, with `wr_valid_o`=1. It is complemented when `wr_pol_i`=1 and passed unchanged when `wr_pol_i`=0. This happens whether or not the function is on.
- R10: While the function is on, no accepted burst word changes more than 8 bits of `dq_o` from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_cmd_i | input | 1 | One-cycle pulse that turns the encoding function on |
| burst_start_i | input | 1 | One-cycle pulse that opens a burst |
| rd_valid_i | input | 1 | A read word is offered on rd_data_i |
| rd_burst_i | input | 1 | The offered read word belongs to a burst |
| rd_data_i | input | 16 | Read word from the array |
| dq_o | output | 16 | Encoded output bus |
| pol_o | output | 1 | 1 when dq_o carries complemented data |
| rdy_o | output | 1 | 0 during an inserted wait cycle |
| wr_valid_i | input | 1 | A write or command word is offered |
| wr_pol_i | input | 1 | Host marks the write word as complemented |
| wr_data_i | input | 16 | Write or command word as received |
| wr_valid_o | output | 1 | Restored write word is valid |
| wr_data_o | output | 16 | Restored write word |

## Verification
The hardest case to reach is a word that differs from the held bus value in exactly 8 or exactly 9 bits. The held value is whatever was driven last, possibly complemented, so random data seldom lands on that boundary. The stimulus therefore sets up a known held value with a non-burst read and then offers chosen words at distance 8 and at distance 15. The second hard case is the wait cycle before the second access. It only exists after the first word of an enabled burst has been accepted. The bench keeps a read offered through the first wait cycle so that the ignored read and both wait cycles fall in one sequence.

// File: rtl/bi_pkg.sv
package bi_pkg;

  // Burst sequencer phases; only the two wait phases drop ready.
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT1 = 2'd1,
    SEQ_FIRST = 2'd2,
    SEQ_WAIT2 = 2'd3
  } seq_state_t;

  // Population count over a word zero-extended to 64 bits.
  function automatic int unsigned ones64(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/bi_enable_latch.sv
module bi_enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= 1'b0;
    else if (set_i) en_q <= 1'b1;
  end

  assign en_o = en_q;

  // R2
  sticky_en_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |=> en_q);

endmodule

// File: rtl/bi_burst_seq.sv
module bi_burst_seq
  import bi_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic start_i,
  input  logic accept_i,
  output logic rdy_o
);
  seq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start_i) begin
      st_d = en_i ? SEQ_WAIT1 : SEQ_IDLE;
    end else begin
      unique case (st_q)
        SEQ_WAIT1: st_d = SEQ_FIRST;
        SEQ_FIRST: if (accept_i) st_d = SEQ_WAIT2;
        SEQ_WAIT2: st_d = SEQ_IDLE;
        default:   st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEQ_IDLE;
    else     st_q <= st_d;
  end

  assign rdy_o = !((st_q == SEQ_WAIT1) || (st_q == SEQ_WAIT2));

  // R7
  wait_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdy_o && !start_i) |=> rdy_o);

  // R8
  no_wait_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |-> rdy_o);

endmodule

// File: rtl/bi_tx_encoder.sv
module bi_tx_encoder
  import bi_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         accept_i,
  input  logic         encode_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] dq_o,
  output logic         pol_o
);
  localparam int HALF = W / 2;
  localparam int CW   = $clog2(W + 1);

  logic [W-1:0] dq_q;
  logic         pol_q;
  logic [CW-1:0] flips;
  logic         invert;
  logic [W-1:0] drive_word;

  // Bits that would switch against the word currently on the bus.
  assign flips      = CW'(ones64(64'(data_i ^ dq_q)));
  assign invert     = encode_i && (int'(flips) > HALF);
  assign drive_word = invert ? ~data_i : data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_q  <= '0;
      pol_q <= 1'b0;
    end else if (accept_i) begin
      dq_q  <= drive_word;
      pol_q <= invert;
    end
  end

  assign dq_o  = dq_q;
  assign pol_o = pol_q;

  // R10
  toggle_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_i && encode_i) |=> ($countones(dq_q ^ $past(dq_q)) <= HALF));

  // R3
  recover_chk: assert property (@(posedge clk) disable iff (rst)
    accept_i |=> ((pol_q ? ~dq_q : dq_q) == $past(data_i)));

  // R6
  plain_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_i && !encode_i) |=> !pol_q);

  // R5
  hold_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !accept_i |=> ($stable(dq_q) && $stable(pol_q)));

endmodule

// File: rtl/bi_rx_decoder.sv
module bi_rx_decoder #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic         pol_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic         vld_q;
  logic [W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) word_q <= pol_i ? ~data_i : data_i;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = word_q;

  // R9
  wr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(data_o));

endmodule

// File: rtl/bi_burst_encoder.sv
module bi_burst_encoder #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable_cmd_i,
  input  logic         burst_start_i,
  input  logic         rd_valid_i,
  input  logic         rd_burst_i,
  input  logic [W-1:0] rd_data_i,
  output logic [W-1:0] dq_o,
  output logic         pol_o,
  output logic         rdy_o,
  input  logic         wr_valid_i,
  input  logic         wr_pol_i,
  input  logic [W-1:0] wr_data_i,
  output logic         wr_valid_o,
  output logic [W-1:0] wr_data_o
);
  logic func_on;
  logic rd_accept;
  logic rd_encode;

  assign rd_accept = rd_valid_i && rdy_o && !burst_start_i;
  assign rd_encode = func_on && rd_burst_i;

  bi_enable_latch u_en (
    .clk   (clk),
    .rst   (rst),
    .set_i (enable_cmd_i),
    .en_o  (func_on)
  );

  bi_burst_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .en_i     (func_on),
    .start_i  (burst_start_i),
    .accept_i (rd_accept),
    .rdy_o    (rdy_o)
  );

  bi_tx_encoder #(.W(W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .accept_i (rd_accept),
    .encode_i (rd_encode),
    .data_i   (rd_data_i),
    .dq_o     (dq_o),
    .pol_o    (pol_o)
  );

  bi_rx_decoder #(.W(W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .valid_i (wr_valid_i),
    .pol_i   (wr_pol_i),
    .data_i  (wr_data_i),
    .valid_o (wr_valid_o),
    .data_o  (wr_data_o)
  );

  // R7
  no_take_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_i && !rdy_o) |=> ($stable(dq_o) && $stable(pol_o)));

endmodule

// File: tb/sim_bi_burst_encoder.sv
`timescale 1ns/1ps
module sim_bi_burst_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable_cmd_i = 1'b0, burst_start_i = 1'b0;
  logic        rd_valid_i = 1'b0, rd_burst_i = 1'b0;
  logic [15:0] rd_data_i = '0;
  logic        wr_valid_i = 1'b0, wr_pol_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] dq_o, wr_data_o;
  logic        pol_o, rdy_o, wr_valid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bi_burst_encoder u0 (
    .clk(clk), .rst(rst), .enable_cmd_i(enable_cmd_i), .burst_start_i(burst_start_i),
    .rd_valid_i(rd_valid_i), .rd_burst_i(rd_burst_i), .rd_data_i(rd_data_i),
    .dq_o(dq_o), .pol_o(pol_o), .rdy_o(rdy_o),
    .wr_valid_i(wr_valid_i), .wr_pol_i(wr_pol_i), .wr_data_i(wr_data_i),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 1 = wait before first, 2 = first pending, 3 = wait before second.
  int          m_en = 0, m_phase = 0;
  logic [15:0] m_dq = '0, m_wd = '0;
  bit          m_pol = 0, m_wv = 0, m_enc = 0;

  function automatic int bits_set(input logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) if (v[i]) c++;
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_phase = 0; m_dq = '0; m_pol = 0; m_wv = 0; m_wd = '0; m_enc = 0;
    end else begin
      bit rdy_now, acc;
      rdy_now = !(m_phase == 1 || m_phase == 3);
      acc = rd_valid_i && rdy_now && !burst_start_i;
      m_enc = 0;
      if (acc) begin
        if (rd_burst_i && m_en != 0) begin
          m_enc = 1;
          if (bits_set(rd_data_i ^ m_dq) >= 9) begin m_dq = ~rd_data_i; m_pol = 1; end
          else begin m_dq = rd_data_i; m_pol = 0; end
        end else begin
          m_dq = rd_data_i; m_pol = 0;
        end
      end
      if (burst_start_i)              m_phase = (m_en != 0) ? 1 : 0;
      else if (m_phase == 1)          m_phase = 2;
      else if (m_phase == 2 && acc)   m_phase = 3;
      else if (m_phase == 3)          m_phase = 0;
      m_wv = wr_valid_i;
      if (wr_valid_i) m_wd = wr_pol_i ? ~wr_data_i : wr_data_i;
      if (enable_cmd_i) m_en = 1;
    end
  end

  logic [15:0] last_dq = '0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 dq_o", {16'h0, dq_o}, {16'h0, m_dq});
      check("R3 pol_o", {31'h0, pol_o}, {31'h0, m_pol});
      check("R7 rdy_o", {31'h0, rdy_o}, {31'h0, !(m_phase == 1 || m_phase == 3)});
      check("R9 wr_valid_o", {31'h0, wr_valid_o}, {31'h0, m_wv});
      check("R9 wr_data_o", {16'h0, wr_data_o}, {16'h0, m_wd});
      if (m_enc) check("R10 toggles<=8", {31'h0, bits_set(dq_o ^ last_dq) <= 8}, 32'h1);
      last_dq = dq_o;
    end
  end

  task automatic push(input logic [15:0] d, input logic b);
    rd_valid_i = 1'b1; rd_data_i = d; rd_burst_i = b;
    while (!rdy_o) @(negedge clk);
    @(negedge clk);
    rd_valid_i = 1'b0;
  endtask

  task automatic start_burst();
    burst_start_i = 1'b1;
    @(negedge clk);
    burst_start_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 dq_o", {16'h0, dq_o}, 32'h0);
    check("R1 pol_o", {31'h0, pol_o}, 32'h0);
    check("R1 rdy_o", {31'h0, rdy_o}, 32'h1);
    check("R1 wr_valid_o", {31'h0, wr_valid_o}, 32'h0);

    // R8 / R6: function off, no waits, no inversion
    start_burst();
    check("R8 rdy_o stays high", {31'h0, rdy_o}, 32'h1);
    push(16'hFFFF, 1'b1);
    check("R6 off passthrough dq", {16'h0, dq_o}, 32'hFFFF);
    check("R6 off passthrough pol", {31'h0, pol_o}, 32'h0);
    push(16'h0000, 1'b1);

    // R2 enable
    enable_cmd_i = 1'b1; @(negedge clk); enable_cmd_i = 1'b0;

    // R7 waits; read held through the first wait is ignored
    start_burst();
    check("R7 wait before first", {31'h0, rdy_o}, 32'h0);
    rd_valid_i = 1'b1; rd_data_i = 16'hFFFF; rd_burst_i = 1'b1;
    @(negedge clk);
    check("R7 read in wait ignored", {16'h0, dq_o}, 32'h0);
    push(16'hFFFF, 1'b1);
    check("R3 16 flips inverted dq", {16'h0, dq_o}, 32'h0000);
    check("R3 16 flips inverted pol", {31'h0, pol_o}, 32'h1);
    check("R7 wait before second", {31'h0, rdy_o}, 32'h0);
    push(16'h00FF, 1'b1);
    check("R4 exactly 8 not inverted dq", {16'h0, dq_o}, 32'h00FF);
    check("R4 exactly 8 not inverted pol", {31'h0, pol_o}, 32'h0);
    push(16'hFF01, 1'b1);
    check("R3 15 flips inverted dq", {16'h0, dq_o}, 32'h00FE);
    check("R3 decode recovers", {16'h0, pol_o ? ~dq_o : dq_o}, 32'hFF01);

    // R6 non-burst while on
    push(16'hFFFF, 1'b0);
    check("R6 nonburst dq", {16'h0, dq_o}, 32'hFFFF);
    check("R6 nonburst pol", {31'h0, pol_o}, 32'h0);

    // R5 new burst compared against last driven word
    start_burst();
    push(16'h0000, 1'b1);
    check("R5 across bursts dq", {16'h0, dq_o}, 32'hFFFF);
    check("R5 across bursts pol", {31'h0, pol_o}, 32'h1);
    repeat (3) @(negedge clk);
    check("R5 held when idle", {16'h0, dq_o}, 32'hFFFF);

    // Random bursts, gaps and interleaved non-burst reads
    for (int b = 0; b < 40; b++) begin
      int len;
      len = 1 + int'($urandom_range(0, 11));
      start_burst();
      for (int k = 0; k < len; k++) begin
        logic [15:0] d;
        d = 16'($urandom);
        push(d, 1'b1);
        check("R3 random recover", {16'h0, pol_o ? ~dq_o : dq_o}, {16'h0, d});
        repeat ($urandom_range(0, 2)) @(negedge clk);
      end
      if ($urandom_range(0, 3) == 0) push(16'($urandom), 1'b0);
      if (b == 20) begin
        // R2 repeated command has no effect
        enable_cmd_i = 1'b1; @(negedge clk); enable_cmd_i = 1'b0;
      end
    end

    // R9 writes
    wr_valid_i = 1'b1; wr_pol_i = 1'b1; wr_data_i = 16'h1234;
    @(negedge clk);
    check("R9 inverted write restored", {16'h0, wr_data_o}, 32'hEDCB);
    wr_pol_i = 1'b0; wr_data_i = 16'hA5C3;
    @(negedge clk);
    check("R9 true write kept", {16'h0, wr_data_o}, 32'hA5C3);
    for (int i = 0; i < 30; i++) begin
      wr_valid_i = 1'($urandom); wr_pol_i = 1'($urandom); wr_data_i = 16'($urandom);
      @(negedge clk);
    end
    wr_valid_i = 1'b0;
    @(negedge clk);

    // R2 only reset turns it off
    do_reset();
    start_burst();
    check("R2 off after reset rdy", {31'h0, rdy_o}, 32'h1);
    push(16'hFFFF, 1'b1);
    check("R2 off after reset dq", {16'h0, dq_o}, 32'hFFFF);
    check("R2 off after reset pol", {31'h0, pol_o}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule